// File: doc/BRIEF.md
# RGB Dot-Clock Display Timing Generator

This block drives the timing side of a parallel RGB panel. Two free-running counters track the pixel clock within a line and the line within a frame. From these counters and a set of programmable timing fields, it produces a horizontal sync, a vertical sync, a data-enable strobe and an always-active-high pixel request. The pixel request tells an external fetch engine when a pixel is consumed.

Each of the four panel-facing qualities is chosen by its own bit, so it can be set without affecting the others. The qualities are the two sync polarities, the data-enable polarity and the pixel-clock sampling edge.

The block also holds a pending frame base address. Software may rewrite it at any moment. The block copies it into the current base address output only when a new frame begins.

Software reaches every field through a 32-bit write port. Each register has four aliases:
- a plain write replaces the register;
- the set alias ORs in the written ones;
- the clear alias removes the written ones;
- the fourth alias does nothing.

Top module: `rgb_timing_gen`

## Requirements
- R1: After reset all registers are zero, the generator is stopped, hsync_o, vsync_o and de_o sit at their idle level of 1, pix_req_o, dotclk_fall_o and cur_base_o are 0.
- R2: The line register (index 1) holds the line length in clocks in bits [17:0] and the horizontal sync width in bits [31:18]. While running, hsync is active for the first width clocks of every line of that length, and a line length of 0 behaves as 1.
- R3: The frame register (index 2) holds the frame length in lines in bits [15:0]. When bit 20 of the sync-shape register (index 4) is 1, vsync is active for the first N lines of each frame, with N in bits [17:0] of that register.
- R4: The timing register (index 3) holds the horizontal start offset in bits [27:16] and the vertical start offset in bits [15:0], both counted from the start of the respective sync pulse. The active line count is in bits [31:16] of index 2 and the active pixel count is in bits [17:0] of index 5. de and pix_req_o are active exactly when both the clock and the line position fall inside their windows.
- R5: Bits 27, 26 and 24 of index 4 make vsync, hsync and data-enable active-high when 1 and active-low when 0, each independently. dotclk_fall_o reflects bit 25.
- R6: When bit 20 of index 4 is 0, the vsync width counts pixel clocks from the first clock of the frame, so vsync may end partway through a line.
- R7: Control register (index 0) bit 0 is run and bit 1 is sync-enable. Run starts the generator only when sync-enable is set. Clearing sync-enable forces every output to idle at once while the counters keep advancing, and setting it again resumes output at the current position.
- R8: After run is cleared, the generator keeps running until fetch_idle is 1. It then stops, the counters return to the frame start and all outputs sit idle.
- R9: Address bits [7:4] select the register and address bits [3:2] select the access kind: 0 replaces the register, 1 (offset +4) sets the written bits, 2 (offset +8) clears them, and 3 (offset +12) leaves the register unchanged.
- R10: The pending base (index 6) may be written at any time. cur_base_o takes its value only at the first clock of each running frame and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register index [7:4] and access kind [3:2] |
| wr_data | input | 32 | Write data |
| fetch_idle | input | 1 | High when the fetch side holds no buffered data |
| hsync_o | output | 1 | Horizontal sync, programmable polarity |
| vsync_o | output | 1 | Vertical sync, programmable polarity |
| de_o | output | 1 | Data enable, programmable polarity |
| pix_req_o | output | 1 | Active-high pixel request during the active window |
| dotclk_fall_o | output | 1 | Selected pixel-clock sampling edge, 1 for falling |
| cur_base_o | output | 32 | Frame base address in use |

## Verification
The hardest situations to reach are those where control changes land in the middle of a frame. Three cases matter most:
- rewriting the pending base address mid-frame;
- dropping and restoring sync-enable while the counters keep moving;
- clearing run while the fetch side is still busy.

The bench follows every clock position through whole frames of a small configuration. It issues each of these writes at chosen positions. It then keeps comparing all outputs cycle by cycle against an arithmetic position model, so a swap, a gating change or a stop one clock early or late shows up at once.

// File: rtl/rgb_timing_pkg.sv
package rgb_timing_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 8;
  localparam int NUM_REGS = 7;

  localparam int HCNT_W  = 18;
  localparam int HSW_W   = 14;
  localparam int VCNT_W  = 16;
  localparam int HWAIT_W = 12;
  localparam int VSW_W   = 18;

  localparam int IDX_CTRL  = 0;
  localparam int IDX_LINE  = 1;
  localparam int IDX_FRAME = 2;
  localparam int IDX_WAIT  = 3;
  localparam int IDX_SHAPE = 4;
  localparam int IDX_HACT  = 5;
  localparam int IDX_NEXT  = 6;

  localparam int BIT_RUN      = 0;
  localparam int BIT_SYNC_ON  = 1;
  localparam int BIT_VS_LINES = 20;
  localparam int BIT_POL_DE   = 24;
  localparam int BIT_POL_CLK  = 25;
  localparam int BIT_POL_HS   = 26;
  localparam int BIT_POL_VS   = 27;
  localparam int HWAIT_LSB    = 16;

  typedef enum logic [1:0] {
    WR_PLAIN = 2'd0,
    WR_SET   = 2'd1,
    WR_CLEAR = 2'd2,
    WR_NONE  = 2'd3
  } wr_kind_e;

  typedef struct packed {
    logic vs;
    logic hs;
    logic clk;
    logic de;
  } pol_t;

  function automatic logic [DATA_W-1:0] merge_write(input logic [DATA_W-1:0] old_v,
                                                     input logic [DATA_W-1:0] new_v,
                                                     input wr_kind_e kind);
    case (kind)
      WR_PLAIN: return new_v;
      WR_SET:   return old_v | new_v;
      WR_CLEAR: return old_v & ~new_v;
      default:  return old_v;
    endcase
  endfunction

  function automatic logic in_window(input logic [DATA_W-1:0] pos,
                                     input logic [DATA_W-1:0] start,
                                     input logic [DATA_W-1:0] len);
    logic [DATA_W:0] stop;
    stop = {1'b0, start} + {1'b0, len};
    return (pos >= start) && ({1'b0, pos} < stop);
  endfunction
endpackage

// File: rtl/rgb_timing_regs.sv
module rgb_timing_regs
  import rgb_timing_pkg::*;
#(
  parameter int NREGS = NUM_REGS
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [DATA_W-1:0]            wr_data,
  output logic [NREGS-1:0][DATA_W-1:0] regs_o
);
  localparam int IDX_W = ADDR_W - 4;

  wr_kind_e kind;
  logic     unused_addr_lo;

  assign kind           = wr_kind_e'(wr_addr[3:2]);
  assign unused_addr_lo = ^wr_addr[1:0];

  generate
    for (genvar i = 0; i < NREGS; i++) begin : g_reg
      logic              hit;
      logic [DATA_W-1:0] q;

      assign hit = wr_en && (wr_addr[ADDR_W-1:4] == IDX_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= '0;
        else if (hit) q <= merge_write(q, wr_data, kind);
      end

      assign regs_o[i] = q;
    end
  endgenerate
endmodule

// File: rtl/rgb_timing_counter.sv
module rgb_timing_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] period,
  output logic [W-1:0] cnt,
  output logic         last
);
  assign last = ({1'b0, cnt} + 1'b1) >= {1'b0, period};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (en)  cnt <= last ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/rgb_timing_shaper.sv
module rgb_timing_shaper
  import rgb_timing_pkg::*;
(
  input  logic               out_en,
  input  logic [HCNT_W-1:0]  h_cnt,
  input  logic [VCNT_W-1:0]  v_cnt,
  input  logic [VSW_W-1:0]   f_clk,
  input  logic [HSW_W-1:0]   hs_width,
  input  logic [HWAIT_W-1:0] h_wait,
  input  logic [HCNT_W-1:0]  h_active,
  input  logic [VCNT_W-1:0]  v_wait,
  input  logic [VCNT_W-1:0]  v_active,
  input  logic [VSW_W-1:0]   vs_width,
  input  logic               vs_lines,
  input  pol_t               pol,
  output logic               hsync_o,
  output logic               vsync_o,
  output logic               de_o,
  output logic               pix_req_o
);
  logic hs_act, vs_act, h_win, v_win, win;

  assign hs_act = DATA_W'(h_cnt) < DATA_W'(hs_width);
  assign vs_act = vs_lines ? (DATA_W'(v_cnt) < DATA_W'(vs_width)) : (f_clk < vs_width);
  assign h_win  = in_window(DATA_W'(h_cnt), DATA_W'(h_wait), DATA_W'(h_active));
  assign v_win  = in_window(DATA_W'(v_cnt), DATA_W'(v_wait), DATA_W'(v_active));
  assign win    = h_win && v_win;

  assign hsync_o   = (out_en && hs_act) ? pol.hs : !pol.hs;
  assign vsync_o   = (out_en && vs_act) ? pol.vs : !pol.vs;
  assign de_o      = (out_en && win)    ? pol.de : !pol.de;
  assign pix_req_o = out_en && win;
endmodule

// File: rtl/rgb_timing_gen.sv
module rgb_timing_gen
  import rgb_timing_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              fetch_idle,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              de_o,
  output logic              pix_req_o,
  output logic              dotclk_fall_o,
  output logic [DATA_W-1:0] cur_base_o
);
  logic [NUM_REGS-1:0][DATA_W-1:0] regs;

  rgb_timing_regs #(.NREGS(NUM_REGS)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .regs_o  (regs)
  );

  // Field views of the register bank
  logic               run_bit, sync_on, vs_lines, pol_hs;
  logic [HCNT_W-1:0]  line_period, h_active;
  logic [HSW_W-1:0]   hs_width;
  logic [VCNT_W-1:0]  frame_period, v_active, v_wait;
  logic [HWAIT_W-1:0] h_wait;
  logic [VSW_W-1:0]   vs_width;
  logic [DATA_W-1:0]  next_base;
  pol_t               pol;

  assign run_bit      = regs[IDX_CTRL][BIT_RUN];
  assign sync_on      = regs[IDX_CTRL][BIT_SYNC_ON];
  assign line_period  = regs[IDX_LINE][HCNT_W-1:0];
  assign hs_width     = regs[IDX_LINE][DATA_W-1 -: HSW_W];
  assign frame_period = regs[IDX_FRAME][VCNT_W-1:0];
  assign v_active     = regs[IDX_FRAME][DATA_W-1 -: VCNT_W];
  assign h_wait       = regs[IDX_WAIT][HWAIT_LSB +: HWAIT_W];
  assign v_wait       = regs[IDX_WAIT][VCNT_W-1:0];
  assign vs_width     = regs[IDX_SHAPE][VSW_W-1:0];
  assign vs_lines     = regs[IDX_SHAPE][BIT_VS_LINES];
  assign pol          = '{vs:  regs[IDX_SHAPE][BIT_POL_VS],
                          hs:  regs[IDX_SHAPE][BIT_POL_HS],
                          clk: regs[IDX_SHAPE][BIT_POL_CLK],
                          de:  regs[IDX_SHAPE][BIT_POL_DE]};
  assign pol_hs       = pol.hs;
  assign h_active     = regs[IDX_HACT][HCNT_W-1:0];
  assign next_base    = regs[IDX_NEXT];

  logic unused_bits;
  assign unused_bits = ^{regs[IDX_CTRL][DATA_W-1:2], regs[IDX_WAIT][31:28],
                         regs[IDX_SHAPE][31:28], regs[IDX_SHAPE][23:21],
                         regs[IDX_SHAPE][19:18], regs[IDX_HACT][DATA_W-1:HCNT_W]};

  // Run state: starts only with sync enabled, stops once the fetch side drains
  logic running;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       running <= 1'b0;
    else if (running) begin
      if (!run_bit && fetch_idle) running <= 1'b0;
    end
    else              running <= run_bit && sync_on;
  end

  logic [HCNT_W-1:0] h_cnt;
  logic [VCNT_W-1:0] v_cnt;
  logic              h_last, v_last;

  rgb_timing_counter #(.W(HCNT_W)) u_hcnt (
    .clk(clk), .rst_n(rst_n), .clr(!running), .en(running),
    .period(line_period), .cnt(h_cnt), .last(h_last)
  );

  rgb_timing_counter #(.W(VCNT_W)) u_vcnt (
    .clk(clk), .rst_n(rst_n), .clr(!running), .en(running && h_last),
    .period(frame_period), .cnt(v_cnt), .last(v_last)
  );

  logic frame_start;
  assign frame_start = running && (h_cnt == '0) && (v_cnt == '0);

  // Clocks since frame start, saturating, for clock-unit vertical sync
  logic [VSW_W-1:0] f_clk;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           f_clk <= '0;
    else if (!running || (h_last && v_last)) f_clk <= '0;
    else if (f_clk != '1)                 f_clk <= f_clk + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cur_base_o <= '0;
    else if (frame_start) cur_base_o <= next_base;
  end

  rgb_timing_shaper u_shape (
    .out_en    (running && sync_on),
    .h_cnt     (h_cnt),
    .v_cnt     (v_cnt),
    .f_clk     (f_clk),
    .hs_width  (hs_width),
    .h_wait    (h_wait),
    .h_active  (h_active),
    .v_wait    (v_wait),
    .v_active  (v_active),
    .vs_width  (vs_width),
    .vs_lines  (vs_lines),
    .pol       (pol),
    .hsync_o   (hsync_o),
    .vsync_o   (vsync_o),
    .de_o      (de_o),
    .pix_req_o (pix_req_o)
  );

  assign dotclk_fall_o = pol.clk;
endmodule

// File: rtl/rgb_timing_checker.sv
module rgb_timing_checker
  import rgb_timing_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              running,
  input logic              frame_start,
  input logic [HCNT_W-1:0] h_cnt,
  input logic              h_last,
  input logic              sync_on,
  input logic              fetch_idle,
  input logic [DATA_W-1:0] next_base,
  input logic [DATA_W-1:0] cur_base,
  input logic              pix_req,
  input logic              hsync,
  input logic              pol_hs
);
  p_line_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    running && !h_last |=> h_cnt == $past(h_cnt) + 1'b1);

  p_line_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    running && h_last |=> h_cnt == '0);

  p_idle_hsync_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> hsync == !pol_hs);

  p_start_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> $past(sync_on));

  p_drain_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    running && !fetch_idle |=> running);

  p_idle_no_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !pix_req);

  p_base_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> cur_base == $past(next_base));

  p_base_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(cur_base));
endmodule

bind rgb_timing_gen rgb_timing_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .running     (running),
  .frame_start (frame_start),
  .h_cnt       (h_cnt),
  .h_last      (h_last),
  .sync_on     (sync_on),
  .fetch_idle  (fetch_idle),
  .next_base   (next_base),
  .cur_base    (cur_base_o),
  .pix_req     (pix_req_o),
  .hsync       (hsync_o),
  .pol_hs      (pol_hs)
);

// File: tb/rgb_timing_gen_bench.sv
`timescale 1ns/1ps
module rgb_timing_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        fetch_idle = 1'b1;
  logic        hsync_o, vsync_o, de_o, pix_req_o, dotclk_fall_o;
  logic [31:0] cur_base_o;

  always #4 clk = ~clk;

  rgb_timing_gen u_rgb_timing_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .fetch_idle(fetch_idle), .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
    .pix_req_o(pix_req_o), .dotclk_fall_o(dotclk_fall_o), .cur_base_o(cur_base_o)
  );

  int errors = 0;
  int checks = 0;

  // bench-side configuration and state model
  int P, HS, HW, HA, F, VS, VW, VA;
  bit unit_l, ph, pv, pd;
  bit running_m = 0;
  logic [31:0] ctrl_m = '0, nb_m = '0, cb_m = '0;
  int h = 0, v = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at h=%0d v=%0d: got %0h expected %0h", req, h, v, act, exp);
    end
  endtask

  function automatic logic [31:0] alias_of(input logic [31:0] old_v, input logic [31:0] d,
                                           input logic [1:0] k);
    if (k == 2'd0) return d;
    if (k == 2'd1) return old_v | d;
    if (k == 2'd2) return old_v & ~d;
    return old_v;
  endfunction

  task automatic model_write(input logic [7:0] a, input logic [31:0] d);
    if (a[7:4] == 4'd0) ctrl_m = alias_of(ctrl_m, d, a[3:2]);
    if (a[7:4] == 4'd6) nb_m   = alias_of(nb_m, d, a[3:2]);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    model_write(a, d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic check_pos();
    bit en, hs_on, vs_on, win;
    en    = running_m && ctrl_m[1];
    hs_on = h < HS;
    vs_on = unit_l ? (v < VS) : ((v * P + h) < VS);
    win   = (h >= HW) && (h - HW < HA) && (v >= VW) && (v - VW < VA);
    chk("R2 hsync", 32'(hsync_o), 32'((en && hs_on) ? ph : !ph));
    chk(unit_l ? "R3 vsync" : "R6 vsync", 32'(vsync_o), 32'((en && vs_on) ? pv : !pv));
    chk("R4 de", 32'(de_o), 32'((en && win) ? pd : !pd));
    chk("R4 pix_req", 32'(pix_req_o), 32'(en && win));
    chk("R10 cur_base", cur_base_o, cb_m);
  endtask

  // n cycles of position checks; optional write in cycle k
  task automatic run_cycles(input int n, input int k, input logic [7:0] a, input logic [31:0] d);
    for (int i = 0; i < n; i++) begin
      check_pos();
      if (i == k) begin wr_en = 1'b1; wr_addr = a; wr_data = d; end
      @(posedge clk);
      if (running_m && h == 0 && v == 0) cb_m = nb_m;
      if (i == k) model_write(a, d);
      @(negedge clk);
      wr_en = 1'b0;
      if (running_m) begin
        h++;
        if (h == P) begin h = 0; v++; if (v == F) v = 0; end
      end
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    P = 10; HS = 2; HW = 3; HA = 4; F = 6; VS = 1; VW = 2; VA = 3;
    unit_l = 1; ph = 0; pv = 0; pd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 hsync", 32'(hsync_o), 32'd1);
    chk("R1 vsync", 32'(vsync_o), 32'd1);
    chk("R1 de", 32'(de_o), 32'd1);
    chk("R1 pix_req", 32'(pix_req_o), 32'd0);
    chk("R1 dotclk_fall", 32'(dotclk_fall_o), 32'd0);
    chk("R1 cur_base", cur_base_o, 32'd0);

    // configuration A: active-low, line-unit vsync
    wr(8'h10, (32'd2 << 18) | 32'd10);
    wr(8'h20, (32'd3 << 16) | 32'd6);
    wr(8'h30, (32'd3 << 16) | 32'd2);
    wr(8'h40, (32'd1 << 20) | 32'd1);
    wr(8'h50, 32'd4);
    wr(8'h60, 32'h1000);

    // R7: run without sync-enable starts nothing
    wr(8'h00, 32'h1);
    run_cycles(4, -1, 8'h0, 32'h0);
    run_cycles(1, 0, 8'h04, 32'h2);   // R9 set alias enables sync
    run_cycles(1, -1, 8'h0, 32'h0);
    running_m = 1; h = 0; v = 0;
    run_cycles(70, -1, 8'h0, 32'h0);
    run_cycles(1, 0, 8'h60, 32'h2000); // R10 mid-frame pending write
    run_cycles(60, -1, 8'h0, 32'h0);

    // R7: drop and restore sync-enable mid-frame
    run_cycles(1, 0, 8'h08, 32'h2);
    run_cycles(7, -1, 8'h0, 32'h0);
    run_cycles(1, 0, 8'h04, 32'h2);
    run_cycles(20, -1, 8'h0, 32'h0);

    // R8: clearing run keeps going until fetch side idles
    fetch_idle = 1'b0;
    run_cycles(1, 0, 8'h08, 32'h1);
    run_cycles(6, -1, 8'h0, 32'h0);
    fetch_idle = 1'b1;
    run_cycles(1, -1, 8'h0, 32'h0);
    running_m = 0; h = 0; v = 0;
    run_cycles(3, -1, 8'h0, 32'h0);

    // configuration B: all polarities high, clock-unit vsync
    wr(8'h40, (32'hF << 24) | 32'd13);
    wr(8'h50, 32'd5);
    ph = 1; pv = 1; pd = 1; unit_l = 0; VS = 13; HA = 5;
    chk("R5 dotclk_fall", 32'(dotclk_fall_o), 32'd1);
    chk("R5 idle hsync high-pol", 32'(hsync_o), 32'd0);
    chk("R5 idle de high-pol", 32'(de_o), 32'd0);

    // R9: fourth alias ignored, clear and set aliases touch only their bits
    wr(8'h4C, 32'h0);
    chk("R9 ignored alias", 32'(hsync_o), 32'd0);
    wr(8'h48, 32'h1 << 26);
    chk("R9 clear alias hsync", 32'(hsync_o), 32'd1);
    chk("R9 clear alias vsync untouched", 32'(vsync_o), 32'd0);
    chk("R9 clear alias clk untouched", 32'(dotclk_fall_o), 32'd1);
    wr(8'h44, 32'h1 << 26);
    chk("R9 set alias hsync", 32'(hsync_o), 32'd0);
    wr(8'h4C, 32'h0);
    chk("R9 ignored alias keeps polarity", 32'(hsync_o), 32'd0);

    run_cycles(1, 0, 8'h04, 32'h1);
    run_cycles(1, -1, 8'h0, 32'h0);
    running_m = 1; h = 0; v = 0;
    run_cycles(45, -1, 8'h0, 32'h0);
    run_cycles(1, 0, 8'h60, 32'h3000);
    run_cycles(90, -1, 8'h0, 32'h0);

    summary();
    $finish;
  end
endmodule